// File: doc/BRIEF.md
# Memory ECC Error Event Logger

This block records error events reported by the SEC-DED checker of a memory path that sits behind a posted write buffer. Correctable single-bit events and uncorrectable double-bit events are kept in two separate capture slots. Each slot holds the failing address, the data word, an auxiliary value word and the syndrome. Each slot also has a sticky status flag and a sticky overflow flag. Software reads these flags over a small 32-bit register bus and clears them by writing 1 to them.

A read/write select bit decides which slot the shared readout registers show. A read-only bit reports whether the write buffer still has reads, merges or writes pending. The decoder and the write buffer sit outside the block. Their single-cycle event strobes, the shared event payload and the buffer busy level are plain inputs. Events are always accepted and there is no back-pressure: an event that cannot be stored is counted only as an overflow.

Register word offsets on `bus_addr`:

- 0: control/status
- 1: captured address
- 2: captured data
- 3: captured value
- 4: captured syndrome

Fields narrower than 32 bits read zero-extended. Reads are combinational and writes take effect at the clock edge.

Top module: `ecc_evt_log`

## Requirements
- R1: One clock edge after `sec_evt` is high, the single-bit status flag (offset 0, bit 4) reads 1.
- R2: One clock edge after `ded_evt` is high, the double-bit status flag (offset 0, bit 0) reads 1.
- R3: An event of a type whose status flag is already 1 sets that type's overflow flag (bit 5 for single-bit, bit 1 for double-bit). It leaves the slot's captured address, data, value and syndrome unchanged.
- R4: An event of a type whose status flag is 0 loads the event address, data, value and syndrome into that slot at the same edge that sets the status flag.
- R5: A write to offset 0 with 1 in bit 0, 1, 4 or 5 clears the matching flag. A 0 in those bits leaves the flag alone. Clearing does not erase the captured fields.
- R6: When an event and a clear of the same type's flags happen in the same cycle, the event takes effect and the clear is lost.
- R7: Offset 0 bit 12 is a read/write select. When it is 1, offsets 1 to 4 show the single-bit slot. When it is 0, they show the double-bit slot.
- R8: Offset 0 bit 8 follows `pwb_busy` (1 while the buffer has pending work, 0 once all data is committed). Writes to it have no effect.
- R9: After reset every flag, the select bit and every captured field read 0. Offset 0 bits other than 0, 1, 4, 5, 8 and 12 read 0, and offsets above 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_evt | input | 1 | Single-bit corrected event strobe |
| ded_evt | input | 1 | Double-bit detected event strobe |
| evt_addr | input | ADDR_W | Address of the failing access |
| evt_data | input | DATA_W | Data word of the failing access |
| evt_val | input | VAL_W | Auxiliary value word of the event |
| evt_synd | input | SYND_W | Syndrome of the event |
| pwb_busy | input | 1 | Write buffer has pending work |
| bus_addr | input | BUS_AW | Register word offset |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |

## Verification
The bench builds the block with a 20-bit address, 32-bit data, an 8-bit value and a 7-bit syndrome. The odd address width shows whether the zero-extension of captured fields on the 32-bit bus is correct. The full-width data word makes sure no capture bit is lost. A 4-bit bus offset reaches both the five mapped offsets and unmapped ones up to 15. The bench also drives an event and a clear of the same type in the same cycle, once against a full slot and once against an empty slot, to check that the event takes effect.

// File: rtl/ecc_evt_pkg.sv
package ecc_evt_pkg;
  // control/status bit positions
  localparam int BIT_DED  = 0;
  localparam int BIT_DEDO = 1;
  localparam int BIT_SEC  = 4;
  localparam int BIT_SECO = 5;
  localparam int BIT_BUSY = 8;
  localparam int BIT_SEL  = 12;

  // register word offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_ADDR = 1;
  localparam int OFS_DATA = 2;
  localparam int OFS_VAL  = 3;
  localparam int OFS_SYND = 4;

  // slot indices; the select value equals the index it shows
  localparam int SLOT_DED = 0;
  localparam int SLOT_SEC = 1;
  localparam int NSLOT    = 2;

  localparam int BUS_DW = 32;

  function automatic int stat_bit(input int slot);
    return (slot == SLOT_SEC) ? BIT_SEC : BIT_DED;
  endfunction

  function automatic int ovf_bit(input int slot);
    return (slot == SLOT_SEC) ? BIT_SECO : BIT_DEDO;
  endfunction
endpackage

// File: rtl/ecc_evt_slot.sv
module ecc_evt_slot #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int VW = 8,
  parameter int SW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          clr_stat,
  input  logic          clr_ovf,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [VW-1:0] in_val,
  input  logic [SW-1:0] in_synd,
  output logic          stat,
  output logic          ovf,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data,
  output logic [VW-1:0] cap_val,
  output logic [SW-1:0] cap_synd
);
  logic load;
  assign load = evt && !stat;

  // an event always (re)asserts the flag, so it beats a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (evt)           stat <= 1'b1;
      else if (clr_stat) stat <= 1'b0;
      if (evt && stat)   ovf  <= 1'b1;
      else if (clr_ovf)  ovf  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
      cap_val  <= '0;
      cap_synd <= '0;
    end else if (load) begin
      cap_addr <= in_addr;
      cap_data <= in_data;
      cap_val  <= in_val;
      cap_synd <= in_synd;
    end
  end
endmodule

// File: rtl/ecc_evt_regif.sv
module ecc_evt_regif
  import ecc_evt_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int VW     = 8,
  parameter int SW     = 7,
  parameter int BUS_AW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [BUS_AW-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [BUS_DW-1:0]          bus_wdata,
  input  logic                       busy,
  input  logic [NSLOT-1:0]           stat,
  input  logic [NSLOT-1:0]           ovf,
  input  logic [NSLOT-1:0][AW-1:0]   cap_addr,
  input  logic [NSLOT-1:0][DW-1:0]   cap_data,
  input  logic [NSLOT-1:0][VW-1:0]   cap_val,
  input  logic [NSLOT-1:0][SW-1:0]   cap_synd,
  output logic [NSLOT-1:0]           clr_stat,
  output logic [NSLOT-1:0]           clr_ovf,
  output logic [BUS_DW-1:0]          bus_rdata
);
  logic ctrl_wr;
  logic sel;
  logic unused_wdata;

  assign ctrl_wr = bus_we && (bus_addr == BUS_AW'(OFS_CTRL));
  assign unused_wdata = ^bus_wdata;

  for (genvar s = 0; s < NSLOT; s++) begin : g_clr
    assign clr_stat[s] = ctrl_wr && bus_wdata[stat_bit(s)];
    assign clr_ovf[s]  = ctrl_wr && bus_wdata[ovf_bit(s)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sel <= 1'b0;
    else if (ctrl_wr) sel <= bus_wdata[BIT_SEL];
  end

  logic [BUS_DW-1:0] ctrl_word, f_addr, f_data, f_val, f_synd;

  always_comb begin
    ctrl_word = '0;
    for (int s = 0; s < NSLOT; s++) begin
      ctrl_word[stat_bit(s)] = stat[s];
      ctrl_word[ovf_bit(s)]  = ovf[s];
    end
    ctrl_word[BIT_BUSY] = busy;
    ctrl_word[BIT_SEL]  = sel;
    f_addr = '0;
    f_data = '0;
    f_val  = '0;
    f_synd = '0;
    f_addr[AW-1:0] = cap_addr[sel];
    f_data[DW-1:0] = cap_data[sel];
    f_val[VW-1:0]  = cap_val[sel];
    f_synd[SW-1:0] = cap_synd[sel];
  end

  always_comb begin
    unique case (int'(bus_addr))
      OFS_CTRL: bus_rdata = ctrl_word;
      OFS_ADDR: bus_rdata = f_addr;
      OFS_DATA: bus_rdata = f_data;
      OFS_VAL:  bus_rdata = f_val;
      OFS_SYND: bus_rdata = f_synd;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_evt_log.sv
module ecc_evt_log
  import ecc_evt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int VAL_W  = 8,
  parameter int SYND_W = 7,
  parameter int BUS_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_evt,
  input  logic              ded_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [DATA_W-1:0] evt_data,
  input  logic [VAL_W-1:0]  evt_val,
  input  logic [SYND_W-1:0] evt_synd,
  input  logic              pwb_busy,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  logic [NSLOT-1:0]             evt_vec;
  logic [NSLOT-1:0]             stat_q, ovf_q, clr_stat, clr_ovf;
  logic [NSLOT-1:0][ADDR_W-1:0] cap_addr;
  logic [NSLOT-1:0][DATA_W-1:0] cap_data;
  logic [NSLOT-1:0][VAL_W-1:0]  cap_val;
  logic [NSLOT-1:0][SYND_W-1:0] cap_synd;

  assign evt_vec[SLOT_SEC] = sec_evt;
  assign evt_vec[SLOT_DED] = ded_evt;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    ecc_evt_slot #(.AW(ADDR_W), .DW(DATA_W), .VW(VAL_W), .SW(SYND_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_vec[s]),
      .clr_stat (clr_stat[s]),
      .clr_ovf  (clr_ovf[s]),
      .in_addr  (evt_addr),
      .in_data  (evt_data),
      .in_val   (evt_val),
      .in_synd  (evt_synd),
      .stat     (stat_q[s]),
      .ovf      (ovf_q[s]),
      .cap_addr (cap_addr[s]),
      .cap_data (cap_data[s]),
      .cap_val  (cap_val[s]),
      .cap_synd (cap_synd[s])
    );
  end

  ecc_evt_regif #(
    .AW(ADDR_W), .DW(DATA_W), .VW(VAL_W), .SW(SYND_W), .BUS_AW(BUS_AW)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .busy      (pwb_busy),
    .stat      (stat_q),
    .ovf       (ovf_q),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data),
    .cap_val   (cap_val),
    .cap_synd  (cap_synd),
    .clr_stat  (clr_stat),
    .clr_ovf   (clr_ovf),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/ecc_evt_log_chk.sv
module ecc_evt_log_chk #(
  parameter int AW     = 16,
  parameter int BUS_AW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sec_evt,
  input logic                ded_evt,
  input logic [AW-1:0]       evt_addr,
  input logic                pwb_busy,
  input logic [BUS_AW-1:0]   bus_addr,
  input logic                bus_we,
  input logic                wr_sec_bit,
  input logic [31:0]         bus_rdata,
  input logic [1:0]          stat,
  input logic [1:0]          ovf,
  input logic [1:0][AW-1:0]  cap_addr
);
  logic ctrl_wr;
  assign ctrl_wr = bus_we && (bus_addr == '0);

  AST_SEC_SET: assert property (@(posedge clk) disable iff (!rst_n) sec_evt |=> stat[1]); // R1
  AST_DED_SET: assert property (@(posedge clk) disable iff (!rst_n) ded_evt |=> stat[0]); // R2
  AST_SEC_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (sec_evt && stat[1]) |=> ovf[1]); // R3
  AST_DED_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (ded_evt && stat[0]) |=> ovf[0]); // R3
  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) (sec_evt && stat[1]) |=> $stable(cap_addr[1])); // R3
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (ded_evt && !stat[0]) |=> cap_addr[0] == $past(evt_addr)); // R4
  AST_W1C_SEC: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_wr && wr_sec_bit && !sec_evt) |=> !stat[1]); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_wr && wr_sec_bit && sec_evt) |=> stat[1]); // R6
  AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr == '0) |-> bus_rdata[8] == pwb_busy); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr > BUS_AW'(4)) |-> bus_rdata == '0); // R9
endmodule

bind ecc_evt_log ecc_evt_log_chk #(.AW(ADDR_W), .BUS_AW(BUS_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_evt    (sec_evt),
  .ded_evt    (ded_evt),
  .evt_addr   (evt_addr),
  .pwb_busy   (pwb_busy),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .wr_sec_bit (bus_wdata[4]),
  .bus_rdata  (bus_rdata),
  .stat       (stat_q),
  .ovf        (ovf_q),
  .cap_addr   (cap_addr)
);

// File: tb/ecc_evt_log_test.sv
module ecc_evt_log_test;
  localparam int AW = 20, DW = 32, VW = 8, SW = 7, BAW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           sec_evt = 0, ded_evt = 0, pwb_busy = 0, bus_we = 0;
  logic [AW-1:0]  evt_addr = '0;
  logic [DW-1:0]  evt_data = '0;
  logic [VW-1:0]  evt_val = '0;
  logic [SW-1:0]  evt_synd = '0;
  logic [BAW-1:0] bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;

  ecc_evt_log #(.ADDR_W(AW), .DATA_W(DW), .VAL_W(VW), .SYND_W(SW), .BUS_AW(BAW)) uut (
    .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .ded_evt(ded_evt),
    .evt_addr(evt_addr), .evt_data(evt_data), .evt_val(evt_val), .evt_synd(evt_synd),
    .pwb_busy(pwb_busy), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  chk_req = 1'b0;
  int    n_cmp = 0, n_bad = 0;

  // monitor: pops the expected item and compares, away from the edge
  always @(posedge clk) begin
    item_t it;
    #3;
    if (chk_req) begin
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
      end else begin
        it = q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic expect_rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = BAW'(a);
    bus_we = 1'b0;
    q.push_back('{exp: e, tag: t});
    chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = BAW'(a);
    bus_we = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic fire(input bit s, input bit d, input bit w, input logic [31:0] wd,
                      input logic [AW-1:0] a, input logic [DW-1:0] dt,
                      input logic [VW-1:0] v, input logic [SW-1:0] sy);
    @(negedge clk);
    sec_evt = s; ded_evt = d;
    evt_addr = a; evt_data = dt; evt_val = v; evt_synd = sy;
    if (w) begin
      bus_addr = '0; bus_we = 1'b1; bus_wdata = wd;
    end
    @(negedge clk);
    sec_evt = 0; ded_evt = 0; bus_we = 0;
  endtask

  bit done = 0;
  initial begin
    #(20 * 50000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state R9
    expect_rd(0, 32'h0, "R9 ctrl after reset");
    expect_rd(1, 32'h0, "R9 addr after reset");
    expect_rd(4, 32'h0, "R9 synd after reset");
    // busy mirror and read-only R8
    pwb_busy = 1'b1;
    expect_rd(0, 32'h0000_0100, "R8 busy high");
    pwb_busy = 1'b0;
    wr(0, 32'h0000_0100);
    expect_rd(0, 32'h0, "R8 write to busy ignored");
    // first single-bit capture R1 R4
    fire(1, 0, 0, 0, 20'hF00A1, 32'hDEAD_BEEF, 8'hA5, 7'h5B);
    expect_rd(0, 32'h0000_0010, "R1 sec status");
    wr(0, 32'h0000_1000);
    expect_rd(0, 32'h0000_1010, "R7 select set");
    expect_rd(1, 32'h000F_00A1, "R4 sec addr");
    expect_rd(2, 32'hDEAD_BEEF, "R4 sec data");
    expect_rd(3, 32'h0000_00A5, "R4 sec value");
    expect_rd(4, 32'h0000_005B, "R4 sec synd");
    // second single-bit while full R3
    fire(1, 0, 0, 0, 20'h12345, 32'h1111_2222, 8'h33, 7'h44);
    expect_rd(0, 32'h0000_1030, "R3 sec overflow");
    expect_rd(1, 32'h000F_00A1, "R3 sec addr held");
    expect_rd(2, 32'hDEAD_BEEF, "R3 sec data held");
    // double-bit capture R2, select R7
    fire(0, 1, 0, 0, 20'h0ABCD, 32'hCAFE_F00D, 8'h5A, 7'h7F);
    expect_rd(0, 32'h0000_1031, "R2 ded status");
    wr(0, 32'h0000_0000);
    expect_rd(0, 32'h0000_0031, "R7 select cleared, w0 keeps flags");
    expect_rd(1, 32'h0000_ABCD, "R7 ded addr shown");
    expect_rd(4, 32'h0000_007F, "R7 ded synd shown");
    // w1c of sec flags R5
    wr(0, 32'h0000_0030);
    expect_rd(0, 32'h0000_0001, "R5 sec flags cleared");
    wr(0, 32'h0000_1000);
    expect_rd(1, 32'h000F_00A1, "R5 payload kept after clear");
    // capture again after clear R4
    fire(1, 0, 0, 0, 20'h00777, 32'h0BAD_CAFE, 8'h01, 7'h02);
    expect_rd(0, 32'h0000_1011, "R4 sec recapture status");
    expect_rd(1, 32'h0000_0777, "R4 sec recapture addr");
    expect_rd(3, 32'h0000_0001, "R4 sec recapture value");
    // event vs clear, slot full R6
    fire(0, 1, 1, 32'h0000_1003, 20'hFFFFF, 32'hFFFF_FFFF, 8'hFF, 7'h7F);
    expect_rd(0, 32'h0000_1013, "R6 ded set beats clear");
    wr(0, 32'h0000_0000);
    expect_rd(1, 32'h0000_ABCD, "R3 ded addr held");
    wr(0, 32'h0000_1033);
    expect_rd(0, 32'h0000_1000, "R5 all flags cleared");
    // event vs clear, slot empty R6
    fire(1, 0, 1, 32'h0000_1030, 20'h54321, 32'h0000_0042, 8'h10, 7'h20);
    expect_rd(0, 32'h0000_1010, "R6 sec set beats clear");
    expect_rd(1, 32'h0005_4321, "R6 sec captured");
    // unused bits and offsets R9
    pwb_busy = 1'b1;
    wr(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0000_1100, "R9 unused ctrl bits zero");
    expect_rd(5, 32'h0, "R9 offset 5 zero");
    expect_rd(15, 32'h0, "R9 offset 15 zero");
    wr(7, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0000_1100, "R9 unmapped write ignored");
    done = 1;
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule